// File: doc/BRIEF.md
# Port-Input Permission Gate

This block sits between instruction decode and the I/O bus of a processor core. It takes one port-input request at a time and decides whether the request may proceed. For each request it works out the 16-bit port address and the access width. It then either lets the access go, raises a general-protection fault, or raises an undefined-opcode fault.

A request carries:
- the opcode byte;
- the operand-size attribute;
- a lock-prefix flag;
- an 8-bit immediate and the 16-bit DX value.

The current mode state travels alongside the request: protection enable, the virtual-8086 flag, the current privilege level and the I/O privilege level.

The bitmap is read only when the mode state requires it. That is the case when protection is on and the current privilege is numerically above the I/O privilege level, or when virtual-8086 mode is set. In that case the gate asks the permission-bitmap store for the bits of the accessed port bytes and waits for the answer.

The controller is a three-state machine:
- **IDLE**: ready for a request. From IDLE it goes to CHECK when a bitmap read is needed, and otherwise straight to RESP.
- **CHECK**: the bitmap read is held until the store answers. CHECK goes to RESP on the cycle the read data is valid.
- **RESP**: exactly one verdict strobe is raised for one cycle. RESP always returns to IDLE.

Top module: `ioin_gate`

## Requirements
- R1: Opcodes 0xE4 and 0xE5 take the port from the immediate, zero-extended to 16 bits (range 0 to 255).
- R2: Opcodes 0xEC and 0xED take the port from the full 16-bit DX value.
- R3: Size code 0 means 8 bits, used by 0xE4 and 0xEC. For 0xE5 and 0xED the code is 1 (16 bits) when `req_osz32` is 0 and 2 (32 bits) when it is 1.
- R4: With protection off, or with protection on, the virtual-8086 flag clear and the current privilege at or below the I/O privilege level, the request is allowed and no bitmap read is issued.
- R5: With protection on and either the current privilege above the I/O privilege level or the virtual-8086 flag set, a bitmap read is issued at the port address. Bit i of `bm_rd_data` covers port address+i.
- R6: On a checked request, a fault strobe results if any bitmap bit covering an accessed byte is 1. Bits for bytes beyond the access width have no effect on the verdict.
- R7: An accessed byte whose port number would exceed 65535 counts as denied, whatever the bitmap data says.
- R8: A lock prefix, or an opcode outside 0xE4/0xE5/0xEC/0xED, gives the undefined-opcode strobe. This takes precedence over every other outcome, and no bitmap read is issued.
- R9: Each accepted request yields exactly one of the three strobes, high for a single cycle. It comes one cycle after acceptance when unchecked, and one cycle after `bm_rd_valid` when checked.
- R10: `req_ready` is high only in IDLE. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `bm_rd_req` stays high from the cycle after acceptance until `bm_rd_valid` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate idle, request can be taken |
| req_opcode | input | 8 | Opcode byte |
| req_osz32 | input | 1 | Operand size 32 when 1, 16 when 0 |
| req_lock | input | 1 | Lock prefix present |
| req_imm | input | 8 | Immediate port number |
| req_dx | input | 16 | DX port number |
| mode_pe | input | 1 | Protection enable |
| mode_vm | input | 1 | Virtual-8086 flag |
| mode_cpl | input | 2 | Current privilege level |
| mode_iopl | input | 2 | I/O privilege level |
| bm_rd_req | output | 1 | Bitmap read request |
| bm_rd_addr | output | 16 | First port of the read |
| bm_rd_valid | input | 1 | Bitmap data valid |
| bm_rd_data | input | 4 | Permission bits, bit i for port addr+i |
| out_port | output | 16 | Resolved port address |
| out_size | output | 2 | Size code (0=8, 1=16, 2=32 bits) |
| out_allow | output | 1 | Access allowed strobe |
| out_gp | output | 1 | General-protection fault strobe |
| out_ud | output | 1 | Undefined-opcode fault strobe |

## Verification
The two functions that can meet in one request are the lock or illegal-opcode decode and the privilege-driven bitmap check. The bench provokes this with a locked request issued in virtual-8086 mode at low privilege, to a port whose bitmap bit is set. It judges the result by requiring the undefined-opcode strobe, with no fault strobe and no bitmap read counted by its responder. A second collision, between the width decode and the 65535 boundary, is provoked by a 16-bit access at port 0xFFFF. That access must fault even though the responder returns all-zero bits for the wrapped byte.

// File: rtl/ioin_pkg.sv
package ioin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RESP  = 2'd2
    } ioin_state_e;

    typedef enum logic [1:0] {
        VERD_ALLOW = 2'd0,
        VERD_GP    = 2'd1,
        VERD_UD    = 2'd2
    } ioin_verdict_e;

    localparam logic [1:0] SZ_8  = 2'd0;
    localparam logic [1:0] SZ_16 = 2'd1;
    localparam logic [1:0] SZ_32 = 2'd2;

    localparam logic [7:0] OP_IMM_B  = 8'hE4;
    localparam logic [7:0] OP_IMM_W  = 8'hE5;
    localparam logic [7:0] OP_DX_B   = 8'hEC;
    localparam logic [7:0] OP_DX_W   = 8'hED;
endpackage

// File: rtl/ioin_decode.sv
module ioin_decode
    import ioin_pkg::*;
#(
    parameter int PORT_W    = 16,
    parameter int IMM_W     = 8,
    parameter int MAX_BYTES = 4,
    localparam int NB_W     = $clog2(MAX_BYTES) + 1
) (
    input  logic [7:0]        opcode,
    input  logic              osz32,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PORT_W-1:0] dx,
    output logic              illegal,
    output logic [PORT_W-1:0] port,
    output logic [1:0]        size_code,
    output logic [NB_W-1:0]   nbytes
);
    logic from_imm;
    logic wide;

    always_comb begin
        illegal  = !(opcode == OP_IMM_B || opcode == OP_IMM_W ||
                     opcode == OP_DX_B  || opcode == OP_DX_W);
        from_imm = (opcode == OP_IMM_B) || (opcode == OP_IMM_W);
        wide     = (opcode == OP_IMM_W) || (opcode == OP_DX_W);
        port     = from_imm ? {{(PORT_W-IMM_W){1'b0}}, imm} : dx;
        if (!wide) begin
            size_code = SZ_8;
            nbytes    = NB_W'(1);
        end else if (osz32) begin
            size_code = SZ_32;
            nbytes    = NB_W'(4);
        end else begin
            size_code = SZ_16;
            nbytes    = NB_W'(2);
        end
    end
endmodule

// File: rtl/ioin_guard.sv
module ioin_guard #(
    parameter int PORT_W    = 16,
    parameter int MAX_BYTES = 4,
    localparam int NB_W     = $clog2(MAX_BYTES) + 1
) (
    input  logic                 pe,
    input  logic                 vm,
    input  logic [1:0]           cpl,
    input  logic [1:0]           iopl,
    input  logic [PORT_W-1:0]    port,
    input  logic [NB_W-1:0]      nbytes,
    input  logic [MAX_BYTES-1:0] bits,
    output logic                 need_check,
    output logic                 deny
);
    logic [MAX_BYTES-1:0] byte_bad;

    assign need_check = pe && (vm || (cpl > iopl));

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
        logic [PORT_W:0] end_port;
        logic            covered;
        assign end_port    = {1'b0, port} + (PORT_W+1)'(i);
        assign covered     = (NB_W'(i) < nbytes);
        assign byte_bad[i] = covered && (bits[i] || end_port[PORT_W]);
    end

    assign deny = |byte_bad;
endmodule

// File: rtl/ioin_gate.sv
module ioin_gate
    import ioin_pkg::*;
#(
    parameter int PORT_W    = 16,
    parameter int IMM_W     = 8,
    parameter int MAX_BYTES = 4,
    localparam int NB_W     = $clog2(MAX_BYTES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [7:0]           req_opcode,
    input  logic                 req_osz32,
    input  logic                 req_lock,
    input  logic [IMM_W-1:0]     req_imm,
    input  logic [PORT_W-1:0]    req_dx,
    input  logic                 mode_pe,
    input  logic                 mode_vm,
    input  logic [1:0]           mode_cpl,
    input  logic [1:0]           mode_iopl,
    output logic                 bm_rd_req,
    output logic [PORT_W-1:0]    bm_rd_addr,
    input  logic                 bm_rd_valid,
    input  logic [MAX_BYTES-1:0] bm_rd_data,
    output logic [PORT_W-1:0]    out_port,
    output logic [1:0]           out_size,
    output logic                 out_allow,
    output logic                 out_gp,
    output logic                 out_ud
);
    ioin_state_e   state, state_nxt;
    ioin_verdict_e verdict;
    logic [PORT_W-1:0] lat_port;
    logic [1:0]        lat_size;
    logic [NB_W-1:0]   lat_nbytes;

    logic              dec_illegal;
    logic [PORT_W-1:0] dec_port;
    logic [1:0]        dec_size;
    logic [NB_W-1:0]   dec_nbytes;
    logic              need_check;
    logic              deny;
    logic              accept;
    logic              refuse_op;

    ioin_decode #(.PORT_W(PORT_W), .IMM_W(IMM_W), .MAX_BYTES(MAX_BYTES)) u_decode (
        .opcode    (req_opcode),
        .osz32     (req_osz32),
        .imm       (req_imm),
        .dx        (req_dx),
        .illegal   (dec_illegal),
        .port      (dec_port),
        .size_code (dec_size),
        .nbytes    (dec_nbytes)
    );

    ioin_guard #(.PORT_W(PORT_W), .MAX_BYTES(MAX_BYTES)) u_guard (
        .pe         (mode_pe),
        .vm         (mode_vm),
        .cpl        (mode_cpl),
        .iopl       (mode_iopl),
        .port       (lat_port),
        .nbytes     (lat_nbytes),
        .bits       (bm_rd_data),
        .need_check (need_check),
        .deny       (deny)
    );

    assign accept    = (state == ST_IDLE) && req_valid;
    assign refuse_op = dec_illegal || req_lock;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (refuse_op)       state_nxt = ST_RESP;
                    else if (need_check) state_nxt = ST_CHECK;
                    else                 state_nxt = ST_RESP;
                end
            end
            ST_CHECK: if (bm_rd_valid) state_nxt = ST_RESP;
            ST_RESP:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // request and verdict holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict    <= VERD_ALLOW;
            lat_port   <= '0;
            lat_size   <= SZ_8;
            lat_nbytes <= NB_W'(1);
        end else if (accept) begin
            lat_port   <= dec_port;
            lat_size   <= dec_size;
            lat_nbytes <= dec_nbytes;
            verdict    <= refuse_op ? VERD_UD : VERD_ALLOW;
        end else if ((state == ST_CHECK) && bm_rd_valid) begin
            verdict    <= deny ? VERD_GP : VERD_ALLOW;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        bm_rd_req  = (state == ST_CHECK);
        bm_rd_addr = lat_port;
        out_port   = lat_port;
        out_size   = lat_size;
        out_allow  = (state == ST_RESP) && (verdict == VERD_ALLOW);
        out_gp     = (state == ST_RESP) && (verdict == VERD_GP);
        out_ud     = (state == ST_RESP) && (verdict == VERD_UD);
    end
endmodule

// File: rtl/ioin_gate_chk.sv
module ioin_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic bm_rd_req,
    input logic bm_rd_valid,
    input logic out_allow,
    input logic out_gp,
    input logic out_ud
);
    logic any_strobe;
    assign any_strobe = out_allow | out_gp | out_ud;

    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_allow, out_gp, out_ud}));

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> !any_strobe);

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r5_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bm_rd_req) |-> $past(req_valid && req_ready));

    a_r6_fault_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_gp |-> $past(bm_rd_valid && bm_rd_req));

    a_r8_ud_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        out_ud |-> $past(req_valid && req_ready));
endmodule

bind ioin_gate ioin_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .bm_rd_req   (bm_rd_req),
    .bm_rd_valid (bm_rd_valid),
    .out_allow   (out_allow),
    .out_gp      (out_gp),
    .out_ud      (out_ud)
);

// File: tb/ioin_gate_bench.sv
`timescale 1ns/1ps
module ioin_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = 8'h00;
    logic        req_osz32 = 1'b0;
    logic        req_lock = 1'b0;
    logic [7:0]  req_imm = 8'h00;
    logic [15:0] req_dx = 16'h0000;
    logic        mode_pe = 1'b0;
    logic        mode_vm = 1'b0;
    logic [1:0]  mode_cpl = 2'd0;
    logic [1:0]  mode_iopl = 2'd0;
    logic        bm_rd_req;
    logic [15:0] bm_rd_addr;
    logic        bm_rd_valid = 1'b0;
    logic [3:0]  bm_rd_data = 4'h0;
    logic [15:0] out_port;
    logic [1:0]  out_size;
    logic        out_allow, out_gp, out_ud;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int latency = 0;
    int lat_cnt = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        int          kind;     // 0 allow, 1 gp, 2 ud
        logic [15:0] port;
        logic [1:0]  size;
        int          nreads;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ioin_gate u_ioin_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_osz32(req_osz32), .req_lock(req_lock),
        .req_imm(req_imm), .req_dx(req_dx), .mode_pe(mode_pe), .mode_vm(mode_vm),
        .mode_cpl(mode_cpl), .mode_iopl(mode_iopl), .bm_rd_req(bm_rd_req),
        .bm_rd_addr(bm_rd_addr), .bm_rd_valid(bm_rd_valid), .bm_rd_data(bm_rd_data),
        .out_port(out_port), .out_size(out_size), .out_allow(out_allow),
        .out_gp(out_gp), .out_ud(out_ud)
    );

    function automatic bit bm_bit(input logic [15:0] p);
        return (p[7:0] == 8'h61) || (p == 16'h03F8) || (p == 16'h03F9) || (p == 16'hFFFE);
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // bitmap store model
    always @(posedge clk) begin
        bm_rd_valid <= 1'b0;
        if (bm_rd_req && !bm_rd_valid) begin
            if (lat_cnt >= latency) begin
                lat_cnt <= 0;
                bm_rd_valid <= 1'b1;
                for (int i = 0; i < 4; i++) bm_rd_data[i] <= bm_bit(bm_rd_addr + 16'(i));
                reads <= reads + 1;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // monitor / scoreboard
    int  last_reads = 0;
    bit  prev_strobe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int n;
            int kind;
            n = int'(out_allow) + int'(out_gp) + int'(out_ud);
            if (n > 1) check("R9 multiple strobes", 1'b0, n, 1);
            if (n != 0 && prev_strobe) check("R9 strobe longer than one cycle", 1'b0, 2, 1);
            if (n == 1) begin
                kind = out_gp ? 1 : (out_ud ? 2 : 0);
                if (sb.size() == 0) begin
                    check("R9 unexpected strobe", 1'b0, kind, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " verdict"}, kind == e.kind, kind, e.kind);
                    check({e.tag, " bitmap reads (R4/R5/R8)"}, (reads - last_reads) == e.nreads,
                          reads - last_reads, e.nreads);
                    if (e.kind != 2) begin
                        check({e.tag, " port (R1/R2)"}, out_port == e.port, out_port, e.port);
                        check({e.tag, " size (R3)"}, out_size == e.size, out_size, e.size);
                    end
                end
                last_reads = reads;
            end
            prev_strobe = (n != 0);
        end
    end

    task automatic send(input string tag, input logic [7:0] op, input bit osz, input bit lock,
                        input logic [7:0] imm, input logic [15:0] dx, input bit pe,
                        input bit vm, input logic [1:0] cpl, input logic [1:0] iopl);
        exp_t e;
        bit legal, need, deny;
        int nb;
        legal = (op == 8'hE4) || (op == 8'hE5) || (op == 8'hEC) || (op == 8'hED);
        e.tag  = tag;
        e.port = (op == 8'hE4 || op == 8'hE5) ? {8'h00, imm} : dx;
        if (op == 8'hE5 || op == 8'hED) begin
            e.size = osz ? 2'd2 : 2'd1;
            nb = osz ? 4 : 2;
        end else begin
            e.size = 2'd0;
            nb = 1;
        end
        need = pe && (vm || (cpl > iopl));
        deny = 1'b0;
        for (int i = 0; i < nb; i++) begin
            int p;
            p = int'(e.port) + i;
            if (p > 65535 || bm_bit(16'(p))) deny = 1'b1;
        end
        if (!legal || lock) begin
            e.kind = 2; e.nreads = 0; need = 1'b0;
        end else if (need) begin
            e.kind = deny ? 1 : 0; e.nreads = 1;
        end else begin
            e.kind = 0; e.nreads = 0;
        end
        sb.push_back(e);

        @(negedge clk);
        req_opcode = op; req_osz32 = osz; req_lock = lock; req_imm = imm; req_dx = dx;
        mode_pe = pe; mode_vm = vm; mode_cpl = cpl; mode_iopl = iopl;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_opcode = 8'h00; req_dx = 16'hFFFF; mode_cpl = 2'd0; mode_vm = 1'b0;
        check({tag, " R10 ready low after accept"}, !req_ready, req_ready, 0);
        if (need) check({tag, " R10 read held after accept"}, bm_rd_req, bm_rd_req, 1);
        else      check({tag, " R9 strobe one cycle after accept"},
                        out_allow | out_gp | out_ud, 0, 1);
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1'b0, 0, 1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset ready", req_ready == 1'b1, req_ready, 1);
        check("R9 reset strobes", {out_allow, out_gp, out_ud} == 3'b000,
              {out_allow, out_gp, out_ud}, 0);
        check("R10 reset no read", bm_rd_req == 1'b0, bm_rd_req, 0);
        rst_n = 1'b1;

        for (int l = 0; l < 3; l++) begin
            latency = (l == 2) ? 3 : l;
            send("R1 R4 imm byte real mode",   8'hE4, 0, 0, 8'h60, 16'h1111, 0, 0, 2'd3, 2'd0);
            send("R3 R4 imm word priv ok",     8'hE5, 0, 0, 8'h80, 16'h0000, 1, 0, 2'd0, 2'd3);
            send("R4 cpl equals iopl",         8'hE5, 1, 0, 8'h61, 16'h0000, 1, 0, 2'd2, 2'd2);
            send("R4 vm ignored without pe",   8'hEC, 0, 0, 8'h00, 16'h0061, 0, 1, 2'd3, 2'd0);
            send("R2 R5 dx dword checked",     8'hED, 1, 0, 8'h00, 16'h1234, 1, 0, 2'd3, 2'd0);
            send("R6 dx byte denied",          8'hEC, 0, 0, 8'h00, 16'h0061, 1, 0, 2'd3, 2'd0);
            send("R5 R6 vm byte ignores bit1", 8'hE4, 0, 0, 8'h60, 16'h0000, 1, 1, 2'd0, 2'd3);
            send("R6 vm word hits bit1",       8'hE5, 0, 0, 8'h60, 16'h0000, 1, 1, 2'd0, 2'd3);
            send("R6 dword upper byte denied", 8'hED, 1, 0, 8'h00, 16'h03F6, 1, 0, 2'd3, 2'd0);
            send("R7 word past top denied",    8'hED, 0, 0, 8'h00, 16'hFFFF, 1, 0, 2'd3, 2'd0);
            send("R7 byte at top allowed",     8'hEC, 0, 0, 8'h00, 16'hFFFF, 1, 0, 2'd3, 2'd0);
            send("R5 dword imm across 0x100",  8'hE5, 1, 0, 8'hFE, 16'h0000, 1, 0, 2'd2, 2'd1);
            send("R8 lock beats denied check", 8'hEC, 0, 1, 8'h00, 16'h0061, 1, 1, 2'd3, 2'd0);
            send("R8 illegal opcode",          8'hE6, 0, 0, 8'h60, 16'h0000, 1, 0, 2'd3, 2'd0);
        end

        repeat (4) @(negedge clk);
        check("R9 no stray results", sb.size() == 0, sb.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule